// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Tracker

This block watches the clock-enable line and the command pins of a two-bank synchronous graphics DRAM. From them it works out which power condition the device is in: normal operation, power-down, self-refresh or clock suspend. Each cycle it looks at the clock-enable level from the previous cycle and the level in the current cycle. It then applies the entry, hold and exit rules that belong to the present condition.

A per-bank idle vector comes from the bank state machines, which sit outside this block. The tracker uses it to allow the low-power entries only when every bank is idle. After an exit from self-refresh or from power-down, a down-counter holds off new commands for a set number of cycles. The block reports three things: the current condition, whether a command may be issued this cycle, and a registered flag that marks illegal commands.

Top module: `sdram_cke_tracker`

## Requirements
- R1: After a synchronous reset, the state output is 0 (normal), `cmd_ok_o` is 1 and `illegal_o` is 0.
- R2: Command decode works as follows. `cs_n` high is a deselect. With `cs_n` low, RAS/CAS/WE = 1/1/1 is a NOP. RAS/CAS/WE = 0/0/1 with DSF low is a refresh, and the same pattern with DSF high is not a refresh. Deselect and NOP both count as "no command".
- R3: In state 0 with every bank idle, clock-enable high in the previous cycle and low now, together with no command, gives state 1 (power-down) in the next cycle.
- R4: Under the same conditions, a refresh command gives state 2 (self-refresh) in the next cycle.
- R5: Under the same conditions, any other command raises `illegal_o` in the next cycle, and the state stays 0.
- R6: In state 1 or 2 with clock-enable low, the state is kept. Commands are ignored and `illegal_o` stays low.
- R7: In state 1 or 2 with clock-enable high, no command gives state 0 in the next cycle. Any other command raises `illegal_o` in the next cycle and leaves the state unchanged.
- R8: After a self-refresh exit in cycle m, `cmd_ok_o` is low until cycle m+TRC_CYC and high from that cycle on.
- R9: After a power-down exit in cycle m, `cmd_ok_o` is low until cycle m+TSS_CYC+1 and high from that cycle on.
- R10: In state 0 with clock-enable high in the previous cycle, a command other than "no command" issued while `cmd_ok_o` is low raises `illegal_o` in the next cycle.
- R11: In state 0 with any bank not idle, a high-to-low clock-enable transition gives state 3 (clock suspend) in the next cycle. If the command in that cycle is a refresh, `illegal_o` is also raised.
- R12: In state 3, clock-enable held low keeps state 3 and commands are ignored. Clock-enable high gives state 0 in the next cycle.
- R13: In state 0 with clock-enable high in both cycles, a refresh while any bank is not idle raises `illegal_o` in the next cycle. Other commands pass without the flag. `illegal_o` is high only for the one cycle after the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_i | input | 1 | Sampled clock-enable level |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| dsf_i | input | 1 | Special-function select; must be low for refresh |
| bank_idle_i | input | NUM_BANKS | Per-bank idle status, 1 = idle |
| pwr_state_o | output | 2 | 0 normal, 1 power-down, 2 self-refresh, 3 clock suspend |
| cmd_ok_o | output | 1 | A command may be issued this cycle |
| illegal_o | output | 1 | Previous cycle carried an illegal command |

## Verification
The bench builds the tracker with two banks, TRC_CYC = 5 and TSS_CYC = 1. With these values both lockout windows are short enough to step through one cycle at a time. This means the first cycle in which `cmd_ok_o` rises after each exit can be checked exactly, and a non-NOP command can be placed inside the one-cycle power-down window. Driving the idle vector to a partly busy pattern brings the clock-suspend path and the bank-state refresh rule within reach.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

   typedef enum logic [1:0] {
      PS_NORMAL  = 2'd0,
      PS_PWRDN   = 2'd1,
      PS_SELFREF = 2'd2,
      PS_SUSPEND = 2'd3
   } pwr_state_e;

   typedef enum logic [1:0] {
      CK_DESEL = 2'd0,
      CK_NOP   = 2'd1,
      CK_REF   = 2'd2,
      CK_OTHER = 2'd3
   } cmd_kind_e;

endpackage

// File: rtl/cke_trk_cmd_dec.sv
module cke_trk_cmd_dec
   import cke_trk_pkg::*;
(
   input  logic      cs_n_i,
   input  logic      ras_n_i,
   input  logic      cas_n_i,
   input  logic      we_n_i,
   input  logic      dsf_i,
   output cmd_kind_e kind_o
);

   always_comb begin
      if (cs_n_i)
         kind_o = CK_DESEL;
      else if (ras_n_i && cas_n_i && we_n_i)
         kind_o = CK_NOP;
      else if (!ras_n_i && !cas_n_i && we_n_i && !dsf_i)
         kind_o = CK_REF;
      else
         kind_o = CK_OTHER;
   end

endmodule

// File: rtl/cke_trk_lockout.sv
module cke_trk_lockout #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic load_i,
   output logic busy_o
);

   localparam int unsigned CW = $clog2(CYCLES + 2);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/cke_trk_fsm.sv
module cke_trk_fsm
   import cke_trk_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cke_i,
   input  cmd_kind_e            kind_i,
   input  logic [NUM_BANKS-1:0] bank_idle_i,
   input  logic                 locked_i,
   output pwr_state_e           state_o,
   output logic                 illegal_o,
   output logic                 trc_load_o,
   output logic                 tss_load_o
);

   // running AND over banks, one stage per bank
   logic [NUM_BANKS:0] idle_chain;
   assign idle_chain[0] = 1'b1;
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_idle
      assign idle_chain[b+1] = idle_chain[b] & bank_idle_i[b];
   end
   logic all_idle;
   assign all_idle = idle_chain[NUM_BANKS];

   pwr_state_e state_q, state_d;
   logic       cke_q;
   logic       ill_q, ill_d;
   logic       no_cmd;

   assign no_cmd = (kind_i == CK_DESEL) || (kind_i == CK_NOP);

   always_comb begin
      state_d    = state_q;
      ill_d      = 1'b0;
      trc_load_o = 1'b0;
      tss_load_o = 1'b0;
      unique case (state_q)
         PS_NORMAL: begin
            if (cke_q) begin
               if (locked_i && !no_cmd)
                  ill_d = 1'b1;
               if (cke_i) begin
                  if (kind_i == CK_REF && !all_idle)
                     ill_d = 1'b1;
               end else if (all_idle) begin
                  if (no_cmd)
                     state_d = PS_PWRDN;
                  else if (kind_i == CK_REF && !locked_i)
                     state_d = PS_SELFREF;
                  else
                     ill_d = 1'b1;
               end else begin
                  state_d = PS_SUSPEND;
                  if (kind_i == CK_REF)
                     ill_d = 1'b1;
               end
            end
         end
         PS_PWRDN, PS_SELFREF: begin
            if (cke_i) begin
               if (no_cmd) begin
                  state_d    = PS_NORMAL;
                  trc_load_o = (state_q == PS_SELFREF);
                  tss_load_o = (state_q == PS_PWRDN);
               end else begin
                  ill_d = 1'b1;
               end
            end
         end
         PS_SUSPEND: begin
            if (cke_i)
               state_d = PS_NORMAL;
         end
         default: state_d = PS_NORMAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PS_NORMAL;
         cke_q   <= 1'b1;
         ill_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cke_q   <= cke_i;
         ill_q   <= ill_d;
      end
   end

   assign state_o   = state_q;
   assign illegal_o = ill_q;

endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
   import cke_trk_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned TRC_CYC   = 10,
   parameter int unsigned TSS_CYC   = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cke_i,
   input  logic                 cs_n_i,
   input  logic                 ras_n_i,
   input  logic                 cas_n_i,
   input  logic                 we_n_i,
   input  logic                 dsf_i,
   input  logic [NUM_BANKS-1:0] bank_idle_i,
   output logic [1:0]           pwr_state_o,
   output logic                 cmd_ok_o,
   output logic                 illegal_o
);

   localparam int unsigned TRC_LOAD = TRC_CYC - 1;

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end
   if (TRC_CYC < 2) begin : g_bad_trc
      $error("TRC_CYC must be at least 2");
   end

   cmd_kind_e  kind;
   pwr_state_e state;
   logic       trc_load, tss_load, trc_busy, tss_busy, locked;

   cke_trk_cmd_dec u_dec (
      .cs_n_i (cs_n_i),
      .ras_n_i(ras_n_i),
      .cas_n_i(cas_n_i),
      .we_n_i (we_n_i),
      .dsf_i  (dsf_i),
      .kind_o (kind)
   );

   cke_trk_lockout #(.CYCLES(TRC_LOAD)) u_trc (
      .clk   (clk),
      .rst   (rst),
      .load_i(trc_load),
      .busy_o(trc_busy)
   );

   cke_trk_lockout #(.CYCLES(TSS_CYC)) u_tss (
      .clk   (clk),
      .rst   (rst),
      .load_i(tss_load),
      .busy_o(tss_busy)
   );

   assign locked = trc_busy | tss_busy;

   cke_trk_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .cke_i      (cke_i),
      .kind_i     (kind),
      .bank_idle_i(bank_idle_i),
      .locked_i   (locked),
      .state_o    (state),
      .illegal_o  (illegal_o),
      .trc_load_o (trc_load),
      .tss_load_o (tss_load)
   );

   assign pwr_state_o = state;
   assign cmd_ok_o    = (state == PS_NORMAL) && !locked;

endmodule

// File: rtl/cke_trk_checker.sv
module cke_trk_checker #(
   parameter int unsigned NUM_BANKS = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cke_i,
   input logic                 cs_n_i,
   input logic                 ras_n_i,
   input logic                 cas_n_i,
   input logic                 we_n_i,
   input logic [NUM_BANKS-1:0] bank_idle_i,
   input logic [1:0]           pwr_state_o,
   input logic                 cmd_ok_o,
   input logic                 illegal_o
);

   logic quiet;
   assign quiet = cs_n_i | (ras_n_i & cas_n_i & we_n_i);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (pwr_state_o == 2'd0 && !illegal_o));

   assert_busy_no_lowpower_R11: assert property (@(posedge clk) disable iff (rst)
      (pwr_state_o == 2'd0 && !(&bank_idle_i)) |=>
         (pwr_state_o != 2'd1 && pwr_state_o != 2'd2));

   assert_lowpower_hold_R6: assert property (@(posedge clk) disable iff (rst)
      ((pwr_state_o == 2'd1 || pwr_state_o == 2'd2) && !cke_i) |=>
         ($stable(pwr_state_o) && !illegal_o));

   assert_exit_clean_R7: assert property (@(posedge clk) disable iff (rst)
      ((pwr_state_o == 2'd1 || pwr_state_o == 2'd2) && cke_i && quiet) |=>
         (pwr_state_o == 2'd0 && !cmd_ok_o));

   assert_suspend_hold_R12: assert property (@(posedge clk) disable iff (rst)
      (pwr_state_o == 2'd3 && !cke_i) |=> (pwr_state_o == 2'd3 && !illegal_o));

   assert_suspend_leave_R12: assert property (@(posedge clk) disable iff (rst)
      (pwr_state_o == 2'd3 && cke_i) |=> pwr_state_o == 2'd0);

   assert_no_cmd_outside_normal_R8: assert property (@(posedge clk) disable iff (rst)
      (pwr_state_o != 2'd0) |-> !cmd_ok_o);

endmodule

bind sdram_cke_tracker cke_trk_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cke_i      (cke_i),
   .cs_n_i     (cs_n_i),
   .ras_n_i    (ras_n_i),
   .cas_n_i    (cas_n_i),
   .we_n_i     (we_n_i),
   .bank_idle_i(bank_idle_i),
   .pwr_state_o(pwr_state_o),
   .cmd_ok_o   (cmd_ok_o),
   .illegal_o  (illegal_o)
);

// File: tb/sdram_cke_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cke_tracker_bench;

   localparam int NB  = 2;
   localparam int TRC = 5;
   localparam int TSS = 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
   logic [NB-1:0] idle = '1;
   logic [1:0] st;
   logic ok, ill;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sdram_cke_tracker #(.NUM_BANKS(NB), .TRC_CYC(TRC), .TSS_CYC(TSS)) u_sdram_cke_tracker (
      .clk(clk), .rst(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
      .cas_n_i(cas_n), .we_n_i(we_n), .dsf_i(dsf), .bank_idle_i(idle),
      .pwr_state_o(st), .cmd_ok_o(ok), .illegal_o(ill)
   );

   typedef enum int {C_NOP, C_DESEL, C_REF, C_ACT, C_REF_DSF} cmd_t;

   task automatic step(input logic k, input cmd_t c);
      cke = k;
      dsf = 1'b0;
      case (c)
         C_NOP:     {cs_n, ras_n, cas_n, we_n} = 4'b0111;
         C_DESEL:   {cs_n, ras_n, cas_n, we_n} = 4'b1000;
         C_REF:     {cs_n, ras_n, cas_n, we_n} = 4'b0001;
         C_ACT:     {cs_n, ras_n, cas_n, we_n} = 4'b0011;
         C_REF_DSF: begin {cs_n, ras_n, cas_n, we_n} = 4'b0001; dsf = 1'b1; end
         default:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      endcase
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      idle = '1;
      step(1'b1, C_NOP);
      for (int i = 0; i < TRC + 1; i++) step(1'b1, C_NOP);
   endtask

   task automatic t_reset();
      chk("R1 state", st, 0);
      chk("R1 cmd_ok", ok, 1);
      chk("R1 illegal", ill, 0);
   endtask

   task automatic t_powerdown();
      settle();
      step(1'b0, C_NOP);
      chk("R3 enter pd", st, 1);
      step(1'b0, C_REF);
      chk("R6 pd hold", st, 1);
      chk("R6 pd ignore", ill, 0);
      step(1'b1, C_NOP);
      chk("R7 pd exit", st, 0);
      chk("R9 lockout low", ok, 0);
      step(1'b1, C_ACT);
      chk("R10 cmd in lockout", ill, 1);
      chk("R9 lockout over", ok, 1);
      step(1'b1, C_NOP);
      chk("R13 flag one cycle", ill, 0);
   endtask

   task automatic t_selfref();
      settle();
      step(1'b0, C_REF);
      chk("R4 enter sr", st, 2);
      chk("R4 cmd_ok low", ok, 0);
      step(1'b0, C_NOP);
      chk("R6 sr hold", st, 2);
      step(1'b1, C_NOP);
      chk("R7 sr exit", st, 0);
      for (int i = 0; i < TRC - 1; i++) begin
         chk("R8 trc low", ok, 0);
         step(1'b1, C_NOP);
      end
      chk("R8 trc done", ok, 1);
   endtask

   task automatic t_bad_exit();
      settle();
      step(1'b0, C_DESEL);
      chk("R2 deselect enters pd", st, 1);
      step(1'b1, C_ACT);
      chk("R7 bad exit flag", ill, 1);
      chk("R7 bad exit stays", st, 1);
      step(1'b1, C_NOP);
      chk("R7 exit after bad", st, 0);
   endtask

   task automatic t_bad_entry();
      settle();
      step(1'b0, C_ACT);
      chk("R5 bad entry flag", ill, 1);
      chk("R5 bad entry state", st, 0);
      step(1'b1, C_NOP);
      settle();
      step(1'b0, C_REF_DSF);
      chk("R2 dsf not refresh", ill, 1);
      chk("R2 dsf state", st, 0);
      step(1'b1, C_NOP);
   endtask

   task automatic t_busy();
      settle();
      idle = 2'b01;
      step(1'b1, C_REF);
      chk("R13 ref busy", ill, 1);
      step(1'b1, C_ACT);
      chk("R13 act passes", ill, 0);
      chk("R11 ok before", ok, 1);
      step(1'b0, C_NOP);
      chk("R11 suspend", st, 3);
      chk("R11 no flag", ill, 0);
      chk("R11 cmd_ok low", ok, 0);
      step(1'b0, C_REF);
      chk("R12 suspend hold", st, 3);
      chk("R12 ignored", ill, 0);
      step(1'b1, C_NOP);
      chk("R12 suspend exit", st, 0);
      step(1'b1, C_NOP);
      step(1'b0, C_REF);
      chk("R11 ref suspend state", st, 3);
      chk("R11 ref flag", ill, 1);
      step(1'b1, C_NOP);
      chk("R12 back normal", st, 0);
      idle = '1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_powerdown();
      t_selfref();
      t_bad_exit();
      t_bad_entry();
      t_busy();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule